// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the low-order address bits for a four-beat burst on a synchronous SRAM. A burst begins when one of two active-low address strobes is sampled low on a rising clock edge. The block then captures the external low address bits and restarts its beat counter at zero. The host strobe only counts when the active-low select input is asserted. The controller strobe always counts.

While neither strobe loads, the burst advances one beat on each edge that sees the active-low step input low. With the step input high, the burst is suspended and holds its current beat. The counter keeps running past the last beat and comes back to the starting address.

A static order input chooses the beat order. Interleaved order combines the start address and the beat count by exclusive-OR. Linear order adds the beat count to the start address modulo the burst length. The upper address bits, the array and the data path are handled elsewhere.

Top module: `burst_seq_gen`

## Requirements
- R1: A cycle with `rst` high leaves `burst_lo` and `beat_idx` at zero after that clock edge.
- R2: With `sel_n` low, `ld_host_n` low on an edge captures `start_lo`. After that edge `beat_idx` is 0 and `burst_lo` equals the captured value.
- R3: `ld_ctrl_n` low on an edge captures `start_lo` and clears `beat_idx` to 0, whatever the level of `sel_n`.
- R4: With `sel_n` high, `ld_host_n` low has no effect. Beat index and captured address stay as they were when `step_n` is high, and the burst advances when `step_n` is low.
- R5: With no load, `step_n` low on an edge raises `beat_idx` by one.
- R6: With no load, `step_n` high on an edge leaves `beat_idx` and `burst_lo` unchanged (burst suspended).
- R7: With `order_ilv` = 1, `burst_lo` equals the captured start XOR `beat_idx`. For example, start 01 yields 01, 00, 11, 10.
- R8: With `order_ilv` = 0, `burst_lo` equals (captured start + `beat_idx`) mod 4. For example, start 10 yields 10, 11, 00, 01.
- R9: An advance from beat 3 returns `beat_idx` to 0 and `burst_lo` to the start address. Further advances continue the sequence.
- R10: A load and a step in the same cycle perform the load only: `beat_idx` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_host_n | input | 1 | Host address strobe, active low, qualified by `sel_n` |
| ld_ctrl_n | input | 1 | Controller address strobe, active low, unqualified |
| step_n | input | 1 | Advance to the next beat, active low |
| sel_n | input | 1 | Select qualifier for the host strobe, active low |
| order_ilv | input | 1 | Order select: 1 interleaved, 0 linear |
| start_lo | input | AW (2) | External low address bits captured on a load |
| burst_lo | output | AW (2) | Current burst address bits |
| beat_idx | output | AW (2) | Current beat number within the burst |

## Verification
Loads, steps, holds and resets are registered. Their effect on `beat_idx` and `burst_lo` appears one clock edge after the cycle in which the inputs are driven. The order input acts through logic only, so a change of `order_ilv` alters `burst_lo` within the same cycle. The bench changes inputs and reads outputs 2 ns after each rising edge, so every check reads the state that the preceding edge produced. The assertions use `|=>` for the registered effects and same-cycle implication for the order mapping.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // events decoded from the strobes for one clock cycle
  typedef struct packed {
    logic load;   // a new burst starts
    logic step;   // move to next beat (only when no load)
    logic host;   // host strobe accepted
    logic ctrl;   // controller strobe accepted
  } burst_evt_t;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_strobe_decode.sv
module burst_strobe_decode
  import burst_seq_pkg::*;
(
  input  logic       ld_host_n,
  input  logic       ld_ctrl_n,
  input  logic       step_n,
  input  logic       sel_n,
  output burst_evt_t evt
);
  logic host_ok;
  logic ctrl_ok;

  // host strobe is masked while the select qualifier is inactive
  assign host_ok = ~ld_host_n & ~sel_n;
  assign ctrl_ok = ~ld_ctrl_n;

  always_comb begin
    evt.host = host_ok;
    evt.ctrl = ctrl_ok;
    evt.load = host_ok | ctrl_ok;
    // load wins over advance
    evt.step = ~(host_ok | ctrl_ok) & ~step_n;
  end
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
  import burst_seq_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  burst_evt_t    evt,
  input  logic [AW-1:0] start_lo,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] beat_q
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (evt.load) begin
      base_q <= start_lo;
      beat_q <= '0;
    end else if (evt.step) begin
      // free-running: wraps after the last beat
      beat_q <= beat_q + ONE;
    end
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int AW          = 2,
  parameter bit INTERLEAVE_EN = 1'b1
) (
  input  logic          order_ilv,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] beat,
  output logic [AW-1:0] addr
);
  function automatic logic [AW-1:0] map_interleave(input logic [AW-1:0] b,
                                                   input logic [AW-1:0] k);
    return b ^ k;
  endfunction

  function automatic logic [AW-1:0] map_linear(input logic [AW-1:0] b,
                                               input logic [AW-1:0] k);
    return b + k;  // modulo 2**AW by width
  endfunction

  generate
    if (INTERLEAVE_EN) begin : g_both
      burst_order_e ord;
      assign ord  = burst_order_e'(order_ilv);
      assign addr = (ord == ORDER_INTERLEAVE) ? map_interleave(base, beat)
                                              : map_linear(base, beat);
    end else begin : g_lin
      logic unused_ord;
      assign unused_ord = order_ilv;
      assign addr = map_linear(base, beat);
    end
  endgenerate
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
  import burst_seq_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_host_n,
  input  logic          ld_ctrl_n,
  input  logic          step_n,
  input  logic          sel_n,
  input  logic          order_ilv,
  input  logic [AW-1:0] start_lo,
  output logic [AW-1:0] burst_lo,
  output logic [AW-1:0] beat_idx
);
  burst_evt_t    evt;
  logic [AW-1:0] base_q;
  logic [AW-1:0] beat_q;
  logic          load_ev;
  logic          step_ev;

  assign load_ev = evt.load;
  assign step_ev = evt.step;

  burst_strobe_decode u_dec (
    .ld_host_n (ld_host_n),
    .ld_ctrl_n (ld_ctrl_n),
    .step_n    (step_n),
    .sel_n     (sel_n),
    .evt       (evt)
  );

  burst_beat_counter #(.AW(AW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .start_lo (start_lo),
    .base_q   (base_q),
    .beat_q   (beat_q)
  );

  burst_order_map #(.AW(AW), .INTERLEAVE_EN(1'b1)) u_map (
    .order_ilv (order_ilv),
    .base      (base_q),
    .beat      (beat_q),
    .addr      (burst_lo)
  );

  assign beat_idx = beat_q;
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          ld_host_n,
  input logic          ld_ctrl_n,
  input logic          step_n,
  input logic          sel_n,
  input logic          order_ilv,
  input logic [AW-1:0] start_lo,
  input logic [AW-1:0] burst_lo,
  input logic [AW-1:0] beat_idx,
  input logic [AW-1:0] base_q,
  input logic          load_ev,
  input logic          step_ev
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (beat_idx == '0 && burst_lo == '0));

  assert_host_load_R2: assert property (@(posedge clk) disable iff (rst)
    (!ld_host_n && !sel_n) |=> (beat_idx == '0 && burst_lo == $past(start_lo)));

  assert_ctrl_load_R3: assert property (@(posedge clk) disable iff (rst)
    !ld_ctrl_n |=> (beat_idx == '0 && burst_lo == $past(start_lo)));

  assert_host_masked_R4: assert property (@(posedge clk) disable iff (rst)
    (!ld_host_n && sel_n && ld_ctrl_n && step_n) |=> ($stable(beat_idx) && $stable(base_q)));

  assert_step_inc_R5: assert property (@(posedge clk) disable iff (rst)
    (ld_ctrl_n && (ld_host_n || sel_n) && !step_n) |=> beat_idx == AW'($past(beat_idx) + 1'b1));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (ld_ctrl_n && (ld_host_n || sel_n) && step_n && !load_ev && !step_ev)
      |=> ($stable(beat_idx) && $stable(base_q)));

  assert_ilv_map_R7: assert property (@(posedge clk) disable iff (rst)
    order_ilv |-> ((burst_lo ^ beat_idx) == base_q));

  assert_lin_map_R8: assert property (@(posedge clk) disable iff (rst)
    !order_ilv |-> (AW'(burst_lo - beat_idx) == base_q));

  assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (step_ev && beat_idx == LAST) |=> beat_idx == '0);

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (load_ev && !step_n) |=> beat_idx == '0);
endmodule

bind burst_seq_gen burst_seq_chk #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .ld_host_n (ld_host_n),
  .ld_ctrl_n (ld_ctrl_n),
  .step_n    (step_n),
  .sel_n     (sel_n),
  .order_ilv (order_ilv),
  .start_lo  (start_lo),
  .burst_lo  (burst_lo),
  .beat_idx  (beat_idx),
  .base_q    (base_q),
  .load_ev   (load_ev),
  .step_ev   (step_ev)
);

// File: tb/burst_seq_gen_tb_top.sv
`timescale 1ns/1ps
module burst_seq_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld_host_n = 1'b1;
  logic       ld_ctrl_n = 1'b1;
  logic       step_n = 1'b1;
  logic       sel_n = 1'b0;
  logic       order_ilv = 1'b1;
  logic [1:0] start_lo = 2'b00;
  logic [1:0] burst_lo;
  logic [1:0] beat_idx;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  burst_seq_gen #(.AW(2)) dut_i (
    .clk(clk), .rst(rst), .ld_host_n(ld_host_n), .ld_ctrl_n(ld_ctrl_n),
    .step_n(step_n), .sel_n(sel_n), .order_ilv(order_ilv),
    .start_lo(start_lo), .burst_lo(burst_lo), .beat_idx(beat_idx)
  );

  // bench-side expectation, bit by bit for interleave, integer sum for linear
  function automatic logic [1:0] want_addr(input logic ilv, input logic [1:0] s,
                                           input int k);
    logic [1:0] kk;
    kk = k[1:0];
    if (ilv) return {s[1] ^ kk[1], s[0] ^ kk[0]};
    return 2'((int'(s) + k) % 4);
  endfunction

  // drive one cycle, then land 2 ns after the edge
  task automatic cyc(input logic hn, input logic cn, input logic sn,
                     input logic stn, input logic [1:0] st);
    ld_host_n = hn; ld_ctrl_n = cn; sel_n = sn; step_n = stn; start_lo = st;
    @(posedge clk); #2;
    ld_host_n = 1'b1; ld_ctrl_n = 1'b1; step_n = 1'b1; sel_n = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [1:0] ea, input logic [1:0] eb);
    total++;
    if (burst_lo !== ea || beat_idx !== eb) begin
      bad++;
      $display("FAIL %s: addr=%b beat=%b expected addr=%b beat=%b",
               tag, burst_lo, beat_idx, ea, eb);
    end
  endtask

  task automatic t_reset_initial;
    rst = 1'b1;
    cyc(1, 1, 0, 1, 2'b00);
    cyc(1, 1, 0, 1, 2'b00);
    chk("R1 initial reset", 2'b00, 2'b00);
    rst = 1'b0;
  endtask

  task automatic t_interleave_seq;
    logic [1:0] exp_a [4] = '{2'b01, 2'b00, 2'b11, 2'b10};
    order_ilv = 1'b1;
    cyc(0, 1, 0, 1, 2'b01);
    chk("R2 host load", 2'b01, 2'b00);
    for (int i = 1; i < 4; i++) begin
      cyc(1, 1, 0, 0, 2'b00);
      chk("R7 interleave beat", exp_a[i], 2'(i));
    end
  endtask

  task automatic t_linear_seq;
    logic [1:0] exp_a [4] = '{2'b10, 2'b11, 2'b00, 2'b01};
    order_ilv = 1'b0;
    cyc(1, 0, 0, 1, 2'b10);
    chk("R3 ctrl load", 2'b10, 2'b00);
    for (int i = 1; i < 4; i++) begin
      cyc(1, 1, 0, 0, 2'b00);
      chk("R8 linear beat / R5 step", exp_a[i], 2'(i));
    end
  endtask

  task automatic t_suspend;
    order_ilv = 1'b0;
    cyc(1, 0, 0, 1, 2'b01);
    cyc(1, 1, 0, 0, 2'b00);
    chk("R5 step", 2'b10, 2'b01);
    cyc(1, 1, 0, 1, 2'b11);
    cyc(1, 1, 1, 1, 2'b11);
    chk("R6 hold", 2'b10, 2'b01);
    cyc(1, 1, 0, 0, 2'b00);
    chk("R6 resume", 2'b11, 2'b10);
  endtask

  task automatic t_host_masked;
    order_ilv = 1'b1;
    cyc(1, 0, 0, 1, 2'b10);
    cyc(0, 1, 1, 1, 2'b01);
    chk("R4 host ignored, held", 2'b10, 2'b00);
    cyc(0, 1, 1, 0, 2'b01);
    chk("R4 host ignored, stepped", 2'b11, 2'b01);
  endtask

  task automatic t_ctrl_ungated;
    order_ilv = 1'b1;
    cyc(1, 0, 1, 1, 2'b11);
    chk("R3 ctrl with select inactive", 2'b11, 2'b00);
  endtask

  task automatic t_wrap;
    order_ilv = 1'b0;
    cyc(1, 0, 0, 1, 2'b11);
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 2'b00);
    chk("R9 wrap to start", 2'b11, 2'b00);
    cyc(1, 1, 0, 0, 2'b00);
    chk("R9 continue after wrap", 2'b00, 2'b01);
  endtask

  task automatic t_load_priority;
    order_ilv = 1'b1;
    cyc(1, 0, 0, 1, 2'b00);
    cyc(1, 1, 0, 0, 2'b00);
    cyc(1, 1, 0, 0, 2'b00);
    cyc(1, 0, 0, 0, 2'b01);
    chk("R10 load over step (ctrl)", 2'b01, 2'b00);
    cyc(1, 1, 0, 0, 2'b00);
    cyc(0, 1, 0, 0, 2'b10);
    chk("R10 load over step (host)", 2'b10, 2'b00);
  endtask

  task automatic t_sweep;
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        order_ilv = m[0];
        cyc(1, 0, 0, 1, 2'(s));
        chk(m == 1 ? "R7 sweep load" : "R8 sweep load", 2'(s), 2'b00);
        for (int k = 1; k < 4; k++) begin
          cyc(1, 1, 0, 0, 2'b00);
          chk(m == 1 ? "R7 sweep" : "R8 sweep", want_addr(m[0], 2'(s), k), 2'(k));
        end
        // order flips within a burst act on the same beat
        order_ilv = ~m[0];
        #1;
        chk("R7/R8 order switch", want_addr(~m[0], 2'(s), 3), 2'b11);
      end
    end
  endtask

  task automatic t_reset_midburst;
    order_ilv = 1'b1;
    cyc(1, 0, 0, 1, 2'b11);
    cyc(1, 1, 0, 0, 2'b00);
    rst = 1'b1;
    cyc(1, 1, 0, 0, 2'b00);
    rst = 1'b0;
    chk("R1 reset mid burst", 2'b00, 2'b00);
  endtask

  initial begin
    #2;
    t_reset_initial();
    t_interleave_seq();
    t_linear_seq();
    t_suspend();
    t_host_masked();
    t_ctrl_ungated();
    t_wrap();
    t_load_priority();
    t_sweep();
    t_reset_midburst();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule